// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a burst starts, a load strobe captures the full starting address. The two low bits become the start offset, and the upper bits are held for the whole burst. On every clock where the active-low advance strobe is low, the block steps to the next beat. The low address bits then follow one of two orders. The linear order counts up modulo four from the start offset. The interleaved order XORs the start offset with the beat number.

The order is chosen by a mode input. The mode input is sampled only together with the load strobe, so it cannot change during a burst. A last-beat flag is high while the fourth beat is presented. The controller uses this flag to end the burst. Read bursts and write bursts use the same stepping. The sequencer has no data path and no memory.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is high at a clock edge, the block goes to an offset of 0 and a beat index of 0. After that edge, `addr_o` reads all zeros and `last_o` reads 0.
- R2: When `load_i` is high at a clock edge, `addr_o` equals `addr_i` after that edge and the beat index restarts at 0. This holds even if `adv_n_i` is low in the same cycle.
- R3: When `load_i` is low and `adv_n_i` is high at a clock edge, `addr_o` and `last_o` keep their values.
- R4: If `mode_i` was 0 at the last load, each advance gives low bits equal to (start + beat) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: If `mode_i` was 1 at the last load, the low bits equal start XOR beat. For example, start 10 gives 10, 11, 00, 01, and start 11 gives 11, 10, 01, 00.
- R6: `last_o` is 1 exactly while the beat index is 3, which is the fourth beat after a load.
- R7: An advance taken on the fourth beat wraps the low bits back to the start offset and clears `last_o`.
- R8: The bits of `addr_o` above bit 1 equal those of `addr_i` at the last load. Advances never change them.
- R9: `mode_i` has no effect except in a cycle where `load_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Starts a burst and captures `addr_i` and `mode_i` |
| addr_i | input | ADDR_W | Starting address of the burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | High on the fourth beat |

## Verification
Every result appears one clock edge after the stimulus that caused it. This covers a load, an advance, a hold and a reset. The state registers feed the outputs through combinational logic only. The bench drives inputs on the falling edge and moves its reference model on the next rising edge. It then samples `addr_o` and `last_o` one nanosecond later, so every check compares the design against the model for the same edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   // Variant selection for the order map
   localparam int VAR_LINEAR_ONLY = 0;
   localparam int VAR_INTLV_ONLY  = 1;
   localparam int VAR_RUNTIME     = 2;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             adv_n_i,
   output logic [OFS_W-1:0] beat_o,
   output logic             last_o
);
   localparam logic [OFS_W-1:0] BEAT_MAX = {OFS_W{1'b1}};
   localparam logic [OFS_W-1:0] BEAT_ONE = {{(OFS_W-1){1'b0}}, 1'b1};

   initial begin
      if (OFS_W < 1) $error("burst_beat_ctr: OFS_W must be at least 1");
   end

   logic [OFS_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (rst)
         beat_q <= '0;
      else if (load_i)
         beat_q <= '0;
      else if (!adv_n_i)
         beat_q <= beat_q + BEAT_ONE;
   end

   assign beat_o = beat_q;
   assign last_o = (beat_q == BEAT_MAX);

   // R2: load restarts the beat count even with advance active
   a_r2_load_restarts: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (beat_o == '0));

   // R3: hold when idle
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!load_i && adv_n_i) |=> $stable(beat_o));

   // R7: the advance after the last beat wraps to the first
   a_r7_wrap_beat: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !adv_n_i && last_o) |=> (beat_o == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int OFS_W   = 2,
   parameter int VARIANT = VAR_RUNTIME
) (
   input  logic [OFS_W-1:0] start_i,
   input  logic [OFS_W-1:0] beat_i,
   input  order_e           order_i,
   output logic [OFS_W-1:0] ofs_o
);
   initial begin
      if (VARIANT < VAR_LINEAR_ONLY || VARIANT > VAR_RUNTIME)
         $error("burst_order_map: VARIANT out of range");
   end

   logic [OFS_W-1:0] lin_ofs;
   logic [OFS_W-1:0] xor_ofs;

   assign lin_ofs = start_i + beat_i;
   assign xor_ofs = start_i ^ beat_i;

   generate
      if (VARIANT == VAR_LINEAR_ONLY) begin : g_lin
         assign ofs_o = lin_ofs;
      end else if (VARIANT == VAR_INTLV_ONLY) begin : g_xor
         assign ofs_o = xor_ofs;
      end else begin : g_sel
         assign ofs_o = (order_i == ORD_INTERLEAVE) ? xor_ofs : lin_ofs;
      end
   endgenerate

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int OFS_W   = 2,
   parameter int VARIANT = VAR_RUNTIME
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              adv_n_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam int UP_W = ADDR_W - OFS_W;

   initial begin
      if (ADDR_W <= OFS_W) $error("burst_seq_top: ADDR_W must exceed OFS_W");
   end

   logic [UP_W-1:0]  base_q;
   logic [OFS_W-1:0] start_q;
   order_e           order_q;
   logic [OFS_W-1:0] beat;
   logic [OFS_W-1:0] ofs;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q  <= '0;
         start_q <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load_i) begin
         base_q  <= addr_i[ADDR_W-1:OFS_W];
         start_q <= addr_i[OFS_W-1:0];
         order_q <= order_e'(mode_i);
      end
   end

   burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load_i),
      .adv_n_i (adv_n_i),
      .beat_o  (beat),
      .last_o  (last_o)
   );

   burst_order_map #(.OFS_W(OFS_W), .VARIANT(VARIANT)) u_map (
      .start_i (start_q),
      .beat_i  (beat),
      .order_i (order_q),
      .ofs_o   (ofs)
   );

   assign addr_o = {base_q, ofs};

   // R8: upper bits stay put between loads
   a_r8_upper_hold: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(addr_o[ADDR_W-1:OFS_W]));

   // R9: the order only changes on a load
   a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(order_q));

   // R7: the offset returns to the start after the fourth beat
   a_r7_wrap_start: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !adv_n_i && last_o) |=> (addr_o[OFS_W-1:0] == start_q));

   // R2: loaded address appears on the next cycle
   a_r2_load_addr: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (addr_o == $past(addr_i)));

endmodule

// File: tb/burst_seq_top_bench.sv
module burst_seq_top_bench;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst;
   logic          load;
   logic [AW-1:0] addr;
   logic          adv_n;
   logic          mode;
   logic [AW-1:0] addr_o;
   logic          last_o;

   int n_run  = 0;
   int n_fail = 0;

   logic [AW-1:0] m_base;
   logic [1:0]    m_beat;
   logic          m_mode;

   always #10 clk = ~clk;

   burst_seq_top #(.ADDR_W(AW)) u_burst_seq_top (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .addr_i  (addr),
      .adv_n_i (adv_n),
      .mode_i  (mode),
      .addr_o  (addr_o),
      .last_o  (last_o)
   );

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                              input logic [1:0] bt,
                                              input logic md);
      logic [1:0] lo;
      lo = md ? (b[1:0] ^ bt) : 2'(b[1:0] + bt);
      return {b[AW-1:2], lo};
   endfunction

   task automatic check(input string tag);
      logic [AW-1:0] ea;
      logic          el;
      ea = exp_addr(m_base, m_beat, m_mode);
      el = (m_beat == 2'd3);
      n_run++;
      if (addr_o !== ea || last_o !== el) begin
         n_fail++;
         $display("FAIL %s: addr_o=%h last_o=%b expected addr_o=%h last_o=%b",
                  tag, addr_o, last_o, ea, el);
      end
   endtask

   task automatic cyc(input logic ld, input logic [AW-1:0] a,
                      input logic an, input logic md, input string tag);
      @(negedge clk);
      load = ld; addr = a; adv_n = an; mode = md;
      @(posedge clk);
      if (ld) begin
         m_base = a; m_beat = 2'd0; m_mode = md;
      end else if (!an) begin
         m_beat = m_beat + 2'd1;
      end
      #1 check(tag);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; load = 1'b0; addr = '0; adv_n = 1'b1; mode = 1'b0;
      m_base = '0; m_beat = 2'd0; m_mode = 1'b1;
      repeat (3) @(posedge clk);
      #1 check("R1 reset");
      @(negedge clk); rst = 1'b0;

      // R4 linear from 01, R6 on the fourth beat, R7 wrap
      cyc(1'b1, 17'h0A5C1, 1'b1, 1'b0, "R2 load linear");
      cyc(1'b0, '0, 1'b0, 1'b1, "R4 beat1 (R9 mode ignored)");
      cyc(1'b0, '0, 1'b0, 1'b0, "R4 beat2");
      cyc(1'b0, '0, 1'b0, 1'b0, "R6 fourth beat");
      cyc(1'b0, '0, 1'b0, 1'b1, "R7 wrap to start");
      cyc(1'b0, '0, 1'b1, 1'b1, "R3 hold");
      cyc(1'b0, '0, 1'b1, 1'b0, "R3 hold again");

      // R5 interleaved from 10 and from 11
      cyc(1'b1, 17'h1FFF2, 1'b1, 1'b1, "R2 load interleaved");
      for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b0, 1'b0, "R5 start 10");
      cyc(1'b1, 17'h00003, 1'b0, 1'b1, "R2 load overrides advance");
      for (int i = 0; i < 3; i++) cyc(1'b0, 17'h1ABCD, 1'b0, 1'b0, "R5 start 11 (R8 upper kept)");
      cyc(1'b0, '0, 1'b1, 1'b0, "R6 last held while idle");
      cyc(1'b0, '0, 1'b0, 1'b0, "R7 interleaved wrap");

      // random mix
      for (int i = 0; i < 600; i++) begin
         cyc(($urandom % 5) == 0, AW'($urandom), ($urandom % 3) == 0,
             1'($urandom), "R8 random mix");
      end

      // R1 reset in mid-burst
      @(negedge clk); rst = 1'b1; load = 1'b0; adv_n = 1'b0;
      @(posedge clk);
      m_base = '0; m_beat = 2'd0; m_mode = 1'b1;
      #1 check("R1 reset mid-burst");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule